// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses, every clock, which word of a 128-word control store the microprogrammed controller runs next. It holds a control address register that drives the control store, and a one-deep return register for microsubroutines. Its inputs are three fields of the microinstruction now being run: a 2-bit condition code, a 2-bit branch kind and a 7-bit target address. It also takes three datapath status bits and the four opcode bits of the fetched machine instruction.

A condition multiplexer reduces the condition code and the status bits to a single test bit. The branch kind and the test bit then pick one of four address sources: the current address plus one, the return register, the target address, or an address formed from the opcode. The branch kinds are JUMP, CALL, RETURN and MAP. The transitions are: in-line step (plus one), branch taken (target), call taken (target, and the return register captures the address plus one), return (return register), and dispatch (mapped opcode). Reset places execution at the start of the fetch routine.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset, active high, sets the control address to 64 and clears the return register to 0. A RETURN issued right after reset therefore goes to address 0.
- R2: The condition code picks the test bit: 00 gives constant 1, 01 gives the indirect bit, 10 gives the sign bit, and 11 gives the accumulator-zero flag.
- R3: With branch kind 00 (JUMP), the next address is the target when the test bit is 1, and the current address plus one when it is 0.
- R4: With branch kind 01 (CALL) and the test bit at 1, the next address is the target and the return register captures the current address plus one in the same edge. With the test bit at 0, the step is in-line and the return register keeps its value.
- R5: With branch kind 10 (RETURN), the next address is the return register contents, whatever the test bit is.
- R6: With branch kind 11 (MAP), the next address is {0, opcode[3:0], 00}, so each opcode lands on a multiple of 4 from 0 to 60.
- R7: The source-select output reads 00 for plus one, 01 for the return register, 10 for the target and 11 for the mapped address. It describes the choice made for the next edge.
- R8: The return-load strobe is high only for a CALL whose test bit is 1.
- R9: The plus-one path wraps modulo 128, so address 127 steps to 0.
- R10: The return register holds a single entry: a second taken CALL replaces the first return address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition code field of the microinstruction |
| br_kind | input | 2 | Branch kind field of the microinstruction |
| tgt_addr | input | 7 | Target address field of the microinstruction |
| ind_bit | input | 1 | Indirect bit of the data register |
| sign_bit | input | 1 | Sign bit of the accumulator |
| acc_zero | input | 1 | Accumulator-equals-zero flag |
| opcode | input | 4 | Opcode bits of the data register |
| car | output | 7 | Control address driven to the control store |
| src_sel | output | 2 | Encoded address source chosen for the next edge |
| sbr_load | output | 1 | Return register load strobe |

## Verification
The assertions take for granted that the microinstruction fields, status bits and opcode are held steady across each clock edge. They also assume reset is driven to a known level from the first edge, since every next-address rule is stated relative to the inputs sampled at that edge. The stimulus changes all inputs only on the falling edge, and it starts with reset high. Random sequences mix all four branch kinds with every condition code. Directed cases cover wrap-around at 127, a return straight after reset, nested calls and untaken calls.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int ADDR_W = 7;
    localparam int OPC_W  = 4;

    typedef enum logic [1:0] {
        BR_JUMP   = 2'b00,
        BR_CALL   = 2'b01,
        BR_RETURN = 2'b10,
        BR_MAP    = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_INC = 2'b00,
        SRC_SBR = 2'b01,
        SRC_TGT = 2'b10,
        SRC_MAP = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CND_ALWAYS = 2'b00,
        CND_IND    = 2'b01,
        CND_SIGN   = 2'b10,
        CND_ZERO   = 2'b11
    } cond_e;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       sign_bit,
    input  logic       acc_zero,
    output logic       test_bit
);
    always_comb begin
        unique case (cond_e'(cond_sel))
            CND_ALWAYS: test_bit = 1'b1;
            CND_IND:    test_bit = ind_bit;
            CND_SIGN:   test_bit = sign_bit;
            CND_ZERO:   test_bit = acc_zero;
            default:    test_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int AW = 7,
    parameter int OW = 4
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] sbr,
    input  logic [AW-1:0] tgt,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] nxt
);
    localparam int PAD_HI = AW - OW - 2;

    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;

    assign inc_addr = cur + AW'(1);

    generate
        if (PAD_HI > 0) begin : g_pad
            assign map_addr = {{PAD_HI{1'b0}}, opcode, 2'b00};
        end else begin : g_nopad
            assign map_addr = {opcode, 2'b00};
        end
    endgenerate

    always_comb begin
        unique case (src_e'(sel))
            SRC_INC: nxt = inc_addr;
            SRC_SBR: nxt = sbr;
            SRC_TGT: nxt = tgt;
            SRC_MAP: nxt = map_addr;
            default: nxt = inc_addr;
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW         = 7,
    parameter int OW         = 4,
    parameter int FETCH_ADDR = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cond_sel,
    input  logic [1:0]    br_kind,
    input  logic [AW-1:0] tgt_addr,
    input  logic          ind_bit,
    input  logic          sign_bit,
    input  logic          acc_zero,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] car,
    output logic [1:0]    src_sel,
    output logic          sbr_load
);
    localparam logic [AW-1:0] RESET_CAR = AW'(FETCH_ADDR);

    logic [AW-1:0] car_q;
    logic [AW-1:0] sbr_q;
    logic [AW-1:0] nxt_addr;
    logic          test_bit;
    src_e          sel_d;
    logic          load_d;

    useq_cond_mux u_cond (
        .cond_sel (cond_sel),
        .ind_bit  (ind_bit),
        .sign_bit (sign_bit),
        .acc_zero (acc_zero),
        .test_bit (test_bit)
    );

    // Output process: branch kind gated by test bit picks the source
    always_comb begin
        sel_d  = SRC_INC;
        load_d = 1'b0;
        unique case (br_kind_e'(br_kind))
            BR_JUMP: begin
                sel_d = test_bit ? SRC_TGT : SRC_INC;
            end
            BR_CALL: begin
                sel_d  = test_bit ? SRC_TGT : SRC_INC;
                load_d = test_bit;
            end
            BR_RETURN: begin
                sel_d = SRC_SBR;
            end
            BR_MAP: begin
                sel_d = SRC_MAP;
            end
            default: begin
                sel_d = SRC_INC;
            end
        endcase
    end

    useq_addr_mux #(.AW(AW), .OW(OW)) u_amux (
        .sel    (sel_d),
        .cur    (car_q),
        .sbr    (sbr_q),
        .tgt    (tgt_addr),
        .opcode (opcode),
        .nxt    (nxt_addr)
    );

    // State process: control address and return register
    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= RESET_CAR;
            sbr_q <= '0;
        end else begin
            car_q <= nxt_addr;
            if (load_d) begin
                sbr_q <= car_q + AW'(1);
            end
        end
    end

    assign car      = car_q;
    assign src_sel  = sel_d;
    assign sbr_load = load_d;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int AW         = 7,
    parameter int OW         = 4,
    parameter int FETCH_ADDR = 64
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    br_kind,
    input logic [AW-1:0] tgt_addr,
    input logic [OW-1:0] opcode,
    input logic [AW-1:0] car,
    input logic [1:0]    src_sel,
    input logic          sbr_load,
    input logic [AW-1:0] sbr_q
);
    // R1
    reset_car_chk: assert property (@(posedge clk)
        rst |=> (car == AW'(FETCH_ADDR)));

    // R9
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00) |=> (car == AW'($past(car) + AW'(1))));

    // R5
    ret_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b01) |=> (car == $past(sbr_q)));

    // R3
    tgt_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b10) |=> (car == $past(tgt_addr)));

    // R6
    map_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b11) |=> (car[1:0] == 2'b00 && car[OW+1:2] == $past(opcode)
                                && car[AW-1] == 1'b0));

    // R4
    sbr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        sbr_load |=> (sbr_q == AW'($past(car) + AW'(1))));

    // R8
    sbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sbr_load |=> $stable(sbr_q));

    // R8
    load_only_call_chk: assert property (@(posedge clk) disable iff (rst)
        sbr_load |-> (br_kind == 2'b01 && src_sel == 2'b10));

    // R7
    ret_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10) |-> (src_sel == 2'b01));
endmodule

bind useq_next_addr useq_chk #(.AW(AW), .OW(OW), .FETCH_ADDR(FETCH_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .br_kind  (br_kind),
    .tgt_addr (tgt_addr),
    .opcode   (opcode),
    .car      (car),
    .src_sel  (src_sel),
    .sbr_load (sbr_load),
    .sbr_q    (sbr_q)
);

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_kind = '0;
    logic [6:0] tgt_addr = '0;
    logic       ind_bit = 1'b0;
    logic       sign_bit = 1'b0;
    logic       acc_zero = 1'b0;
    logic [3:0] opcode = '0;
    logic [6:0] car;
    logic [1:0] src_sel;
    logic       sbr_load;

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0] m_car;
    logic [6:0] m_sbr;

    always #10 clk = ~clk;

    useq_next_addr i_useq_next_addr (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
        .tgt_addr(tgt_addr), .ind_bit(ind_bit), .sign_bit(sign_bit),
        .acc_zero(acc_zero), .opcode(opcode), .car(car),
        .src_sel(src_sel), .sbr_load(sbr_load)
    );

    function automatic logic f_test(logic [1:0] c, logic i, logic s, logic z);
        case (c)
            2'b00: return 1'b1;
            2'b01: return i;
            2'b10: return s;
            default: return z;
        endcase
    endfunction

    function automatic logic [1:0] f_sel(logic [1:0] b, logic t);
        case (b)
            2'b00, 2'b01: return t ? 2'b10 : 2'b00;
            2'b10: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(logic [1:0] c, logic [1:0] b, logic [6:0] a,
                        logic i, logic s, logic z, logic [3:0] op, string req);
        logic       t;
        logic [1:0] es;
        logic [6:0] en;
        @(negedge clk);
        cond_sel = c; br_kind = b; tgt_addr = a;
        ind_bit = i; sign_bit = s; acc_zero = z; opcode = op;
        #2;
        t  = f_test(c, i, s, z);
        es = f_sel(b, t);
        check(src_sel == es, "R7 R2", src_sel, es);
        check(sbr_load == (b == 2'b01 && t), "R8", sbr_load, (b == 2'b01 && t));
        case (es)
            2'b00: en = m_car + 7'd1;
            2'b01: en = m_sbr;
            2'b10: en = a;
            default: en = {1'b0, op, 2'b00};
        endcase
        if (b == 2'b01 && t) m_sbr = m_car + 7'd1;
        m_car = en;
        @(posedge clk);
        #2;
        check(car == m_car, req, car, m_car);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #2;
        check(car == 7'd64, "R1 reset address", car, 64);
        @(negedge clk);
        rst = 1'b0;
        m_car = 7'd64;
        m_sbr = 7'd0;
        // R1: return right after reset lands on cleared register
        step(2'b00, 2'b10, 7'd99, 1'b0, 1'b0, 1'b0, 4'h0, "R1 R5 sbr cleared");
        check(car == 7'd0, "R1", car, 0);
        // R9: wrap at 127
        step(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0, "R3 jump to 127");
        step(2'b01, 2'b00, 7'd5, 1'b0, 1'b0, 1'b0, 4'h0, "R9 wrap");
        check(car == 7'd0, "R9", car, 0);
        // R2: each condition source, true and false
        step(2'b10, 2'b00, 7'd33, 1'b0, 1'b1, 1'b0, 4'h0, "R2 sign taken");
        step(2'b11, 2'b00, 7'd70, 1'b1, 1'b1, 1'b0, 4'h0, "R2 zero not taken");
        step(2'b11, 2'b00, 7'd70, 1'b0, 1'b0, 1'b1, 4'h0, "R2 zero taken");
        // R4 untaken call keeps register, then R10 nested calls
        step(2'b00, 2'b01, 7'd20, 1'b0, 1'b0, 1'b0, 4'h0, "R4 call taken");
        step(2'b01, 2'b01, 7'd90, 1'b0, 1'b0, 1'b0, 4'h0, "R4 call not taken");
        step(2'b00, 2'b10, 7'd0, 1'b0, 1'b0, 1'b0, 4'h0, "R4 return after untaken");
        check(car == 7'd71, "R4 return address", car, 71);
        step(2'b00, 2'b01, 7'd40, 1'b0, 1'b0, 1'b0, 4'h0, "R10 first call");
        step(2'b00, 2'b01, 7'd50, 1'b0, 1'b0, 1'b0, 4'h0, "R10 second call");
        step(2'b01, 2'b10, 7'd9, 1'b1, 1'b0, 1'b0, 4'h0, "R10 R5 return");
        check(car == 7'd41, "R10 overwritten", car, 41);
        // R6: map extremes
        step(2'b00, 2'b11, 7'd3, 1'b0, 1'b0, 1'b0, 4'hF, "R6 map F");
        check(car == 7'd60, "R6", car, 60);
        step(2'b10, 2'b11, 7'd3, 1'b0, 1'b0, 1'b0, 4'h0, "R6 map 0");
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] rb;
            rb = 2'($urandom);
            step(2'($urandom), rb, 7'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 4'($urandom),
                 rb == 2'b00 ? "R3" : rb == 2'b01 ? "R4" : rb == 2'b10 ? "R5" : "R6");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule